// File: doc/BRIEF.md
# Interrupt Request Routing Controller

This block sits between a set of peripheral event lines and three consumers of those events. The consumers are a DMA engine, a descriptor-driven transfer engine, and the CPU interrupt input. For every source it keeps a pending flag. Three configuration bits per source steer that flag to exactly one consumer:

- **DMA-select** sends the source to the DMA engine.
- **transfer-enable** sends it to the transfer engine when DMA-select is clear.
- **notify-CPU** asks for a CPU interrupt after each transfer.

The request on the chosen path is a level. It stays high while the flag is set.

The point at which the flag is cleared depends on the consumer:

- **DMA path:** the DMA engine clears the flag by acknowledging at the start of its transfer.
- **Transfer-engine path:** the flag clears when the engine reports completion. If the engine reports completion with its count at zero, the block clears the source's transfer-enable bit and hands the still-pending flag to the CPU.
- **CPU path:** software clears the flag by writing a one to the flag register. A read that follows the clear shows it has taken effect.

Software reaches four registers through one synchronous write port and one combinational read port. Address 0 holds DMA-select, address 1 holds transfer-enable, address 2 holds notify-CPU, and address 3 holds the pending flags (read) or clears them (write 1). Bit i of each register belongs to source i. The consumer handshakes are plain level and pulse signals, with no stream back-pressure. A request is simply held until its consumer acknowledges or completes.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset all four registers read 0 and every request output (dma_req, xfer_req, cpu_irq) is 0.
- R2: A high src_evt bit sets that source's pending flag at the next clock edge, and address 3 then reads it as 1.
- R3: With DMA-select (address 0) set for a source, a pending flag drives only dma_req; xfer_req and cpu_irq stay 0 whatever transfer-enable and notify-CPU hold.
- R4: A dma_ack bit while that source's dma_req is high clears the flag at the next edge; a dma_ack bit for a source whose dma_req is low has no effect on its flag.
- R5: With DMA-select 0, transfer-enable (address 1) 1 and notify-CPU (address 2) 0, a pending flag drives only xfer_req.
- R6: xfer_done for a source with xfer_req high, xfer_zero low and notify-CPU 0 clears the flag at the next edge without raising cpu_irq.
- R7: xfer_done for a source with xfer_req high and xfer_zero high clears that source's transfer-enable bit, keeps the flag set, drops xfer_req and raises cpu_irq from the next cycle.
- R8: With DMA-select 0 and transfer-enable 0, a pending flag drives cpu_irq, which stays high until software clears the flag.
- R9: Writing 1 to bit i at address 3 clears flag i, so a read of address 3 in the next cycle returns 0 for that bit.
- R10: With transfer-enable 1 and notify-CPU 1, xfer_done with xfer_zero low keeps the flag set, drops xfer_req and raises cpu_irq until software clears the flag.
- R11: When src_evt and any clear of the same source fall in the same cycle, the flag remains set.
- R12: When the hardware clear of a transfer-enable bit (R7) coincides with a software write to address 1, that bit ends at 0 while the other bits take the written value.
- R13: Writes to addresses 0, 1 and 2 are read back unchanged from the same address in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NUM_SRC | Event per source; high for a cycle sets the flag |
| dma_req | output | NUM_SRC | DMA activation request, level |
| dma_ack | input | NUM_SRC | DMA start-of-transfer acknowledge, one cycle |
| xfer_req | output | NUM_SRC | Transfer-engine activation request, level |
| xfer_done | input | NUM_SRC | Transfer-engine completion report, one cycle |
| xfer_zero | input | NUM_SRC | Count-zero indication, valid with xfer_done |
| cpu_irq | output | NUM_SRC | CPU interrupt request, level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register write address |
| cfg_wdata | input | NUM_SRC | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | NUM_SRC | Register read data, combinational |

## Verification
Two pairs of functions can meet in one cycle.

- **Flag set and flag clear.** A fresh event can land on the same source in the same cycle as a software clear, a DMA acknowledge or a transfer completion.
- **Enable-bit clear against a software write.** The hardware clear of a transfer-enable bit on a zero-count completion can coincide with a software write to address 1.

The bench provokes both pairs in directed steps. It then drives a long stretch of randomly mixed events, acknowledges, completions and register writes, so that such coincidences occur on many sources at once. A behavioural model updated on every edge predicts all request outputs and the register read-back. Any mismatch at a sample point is reported against the requirement that owns that output.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_DMA_SEL  = 2'd0,
    REG_XFER_EN  = 2'd1,
    REG_NOTIFY   = 2'd2,
    REG_FLAGS    = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PATH_DMA  = 2'd0,
    PATH_XFER = 2'd1,
    PATH_CPU  = 2'd2
  } route_e;

  typedef struct packed {
    logic dma_sel;
    logic xfer_en;
    logic notify;
  } route_cfg_t;

endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
  import irq_route_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      en_hw_clr,
  output logic [N-1:0]      dma_sel,
  output logic [N-1:0]      xfer_en,
  output logic [N-1:0]      notify,
  output logic [N-1:0]      sw_clr
);

  reg_sel_e sel;
  logic     wr_dma, wr_en, wr_ntf, wr_flg;

  always_comb begin
    sel    = reg_sel_e'(addr);
    wr_dma = we && (sel == REG_DMA_SEL);
    wr_en  = we && (sel == REG_XFER_EN);
    wr_ntf = we && (sel == REG_NOTIFY);
    wr_flg = we && (sel == REG_FLAGS);
  end

  // flag clear strobes, one per source
  assign sw_clr = wr_flg ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_sel <= '0;
      notify  <= '0;
    end else begin
      if (wr_dma) dma_sel <= wdata;
      if (wr_ntf) notify  <= wdata;
    end
  end

  // per-bit enable register: hardware clear beats a software write
  for (genvar i = 0; i < N; i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            xfer_en[i] <= 1'b0;
      else if (en_hw_clr[i]) xfer_en[i] <= 1'b0;
      else if (wr_en)        xfer_en[i] <= wdata[i];
    end
  end

endmodule

// File: rtl/irq_route_src.sv
module irq_route_src
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  route_cfg_t cfg,
  input  logic       evt,
  input  logic       dma_ack,
  input  logic       xfer_done,
  input  logic       xfer_zero,
  input  logic       sw_clr,
  output logic       flag,
  output logic       dma_req,
  output logic       xfer_req,
  output logic       cpu_irq,
  output logic       en_hw_clr
);

  // cpu_owed: the transfer engine has handed this pending flag to the CPU
  logic   cpu_owed;
  route_e path;
  logic   take_xfer, owe_now, clr, flag_d, owed_d;

  always_comb begin
    if (cfg.dma_sel)                    path = PATH_DMA;
    else if (cfg.xfer_en && !cpu_owed)  path = PATH_XFER;
    else                                path = PATH_CPU;
  end

  assign dma_req  = flag && (path == PATH_DMA);
  assign xfer_req = flag && (path == PATH_XFER);
  assign cpu_irq  = flag && (path == PATH_CPU);

  always_comb begin
    take_xfer = xfer_done && xfer_req;
    en_hw_clr = take_xfer && xfer_zero;
    owe_now   = take_xfer && (xfer_zero || cfg.notify);
    clr       = (dma_ack && dma_req)
              || (take_xfer && !xfer_zero && !cfg.notify)
              || sw_clr;
    flag_d    = evt || (flag && !clr);
    owed_d    = flag_d && !clr && (cpu_owed || owe_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      cpu_owed <= 1'b0;
    end else begin
      flag     <= flag_d;
      cpu_owed <= owed_d;
    end
  end

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [REG_AW-1:0] addr,
  input  logic [N-1:0]      dma_sel,
  input  logic [N-1:0]      xfer_en,
  input  logic [N-1:0]      notify,
  input  logic [N-1:0]      flags,
  output logic [N-1:0]      data
);

  always_comb begin
    unique case (reg_sel_e'(addr))
      REG_DMA_SEL: data = dma_sel;
      REG_XFER_EN: data = xfer_en;
      REG_NOTIFY:  data = notify;
      default:     data = flags;
    endcase
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  output logic [NUM_SRC-1:0] dma_req,
  input  logic [NUM_SRC-1:0] dma_ack,
  output logic [NUM_SRC-1:0] xfer_req,
  input  logic [NUM_SRC-1:0] xfer_done,
  input  logic [NUM_SRC-1:0] xfer_zero,
  output logic [NUM_SRC-1:0] cpu_irq,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [NUM_SRC-1:0] cfg_wdata,
  input  logic [1:0]         rd_addr,
  output logic [NUM_SRC-1:0] rd_data
);

  logic [NUM_SRC-1:0] dma_sel, xfer_en, notify, sw_clr, en_hw_clr, flags;

  irq_route_cfg #(.N(NUM_SRC)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .en_hw_clr (en_hw_clr),
    .dma_sel   (dma_sel),
    .xfer_en   (xfer_en),
    .notify    (notify),
    .sw_clr    (sw_clr)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    route_cfg_t cfg_i;
    assign cfg_i = '{dma_sel: dma_sel[i], xfer_en: xfer_en[i], notify: notify[i]};

    irq_route_src u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg_i),
      .evt       (src_evt[i]),
      .dma_ack   (dma_ack[i]),
      .xfer_done (xfer_done[i]),
      .xfer_zero (xfer_zero[i]),
      .sw_clr    (sw_clr[i]),
      .flag      (flags[i]),
      .dma_req   (dma_req[i]),
      .xfer_req  (xfer_req[i]),
      .cpu_irq   (cpu_irq[i]),
      .en_hw_clr (en_hw_clr[i])
    );
  end

  irq_route_rdmux #(.N(NUM_SRC)) u_rd (
    .addr    (rd_addr),
    .dma_sel (dma_sel),
    .xfer_en (xfer_en),
    .notify  (notify),
    .flags   (flags),
    .data    (rd_data)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] src_evt,
  input logic [N-1:0] dma_ack,
  input logic [N-1:0] xfer_done,
  input logic [N-1:0] xfer_zero,
  input logic         cfg_we,
  input logic [1:0]   cfg_addr,
  input logic [N-1:0] cfg_wdata,
  input logic [N-1:0] dma_req,
  input logic [N-1:0] xfer_req,
  input logic [N-1:0] cpu_irq
);

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3 R5
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dma_req[i], xfer_req[i], cpu_irq[i]}));

    // R4
    dma_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req[i] && dma_ack[i] && !src_evt[i])
      |=> !(dma_req[i] || xfer_req[i] || cpu_irq[i]));

    // R7
    zero_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req[i] && xfer_done[i] && xfer_zero[i] && !cfg_we)
      |=> (cpu_irq[i] && !xfer_req[i]));

    // R8
    cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq[i] && !cfg_we) |=> cpu_irq[i]);

    // R11
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt[i] |=> (dma_req[i] || xfer_req[i] || cpu_irq[i]));

    // R12
    en_clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req[i] && xfer_done[i] && xfer_zero[i] && cfg_we
       && cfg_addr == 2'd1 && cfg_wdata[i])
      |=> !xfer_req[i]);
  end

endmodule

bind irq_route_ctrl irq_route_chk #(.N(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_evt   (src_evt),
  .dma_ack   (dma_ack),
  .xfer_done (xfer_done),
  .xfer_zero (xfer_zero),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .dma_req   (dma_req),
  .xfer_req  (xfer_req),
  .cpu_irq   (cpu_irq)
);

// File: tb/tb_irq_route_ctrl.sv
`timescale 1ns/1ps
module tb_irq_route_ctrl;
  localparam int N = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [N-1:0] src_evt = '0, dma_ack = '0, xfer_done = '0, xfer_zero = '0;
  logic         cfg_we = 0;
  logic [1:0]   cfg_addr = '0, rd_addr = '0;
  logic [N-1:0] cfg_wdata = '0;
  logic [N-1:0] dma_req, xfer_req, cpu_irq, rd_data;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  irq_route_ctrl #(.NUM_SRC(N)) dut (.*);

  // behavioural reference state
  bit m_dma[N], m_en[N], m_ntf[N], m_flag[N], m_owed[N];

  function automatic bit m_path(int i, int p); // p: 0 dma, 1 xfer, 2 cpu
    if (!m_flag[i]) return 0;
    if (m_dma[i]) return p == 0;
    if (m_en[i] && !m_owed[i]) return p == 1;
    return p == 2;
  endfunction

  function automatic logic [N-1:0] m_vec(int p);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_path(i, p);
    return v;
  endfunction

  function automatic logic [N-1:0] m_rd(logic [1:0] a);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (a == 0) ? m_dma[i] : (a == 1) ? m_en[i] : (a == 2) ? m_ntf[i] : m_flag[i];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_dma[i] = 0; m_en[i] = 0; m_ntf[i] = 0; m_flag[i] = 0; m_owed[i] = 0;
      end
    end else begin
      bit nd[N], ne[N], nn[N], nf[N], no[N];
      for (int i = 0; i < N; i++) begin
        bit dq, xq, served, clr, owe, hwclr;
        dq = m_path(i, 0); xq = m_path(i, 1);
        served = xfer_done[i] && xq;
        hwclr = served && xfer_zero[i];
        owe = served && (xfer_zero[i] || m_ntf[i]);
        clr = (dma_ack[i] && dq) || (served && !xfer_zero[i] && !m_ntf[i])
              || (cfg_we && cfg_addr == 3 && cfg_wdata[i]);
        nf[i] = src_evt[i] || (m_flag[i] && !clr);
        no[i] = nf[i] && !clr && (m_owed[i] || owe);
        nd[i] = (cfg_we && cfg_addr == 0) ? cfg_wdata[i] : m_dma[i];
        nn[i] = (cfg_we && cfg_addr == 2) ? cfg_wdata[i] : m_ntf[i];
        ne[i] = hwclr ? 1'b0 : (cfg_we && cfg_addr == 1) ? cfg_wdata[i] : m_en[i];
      end
      for (int i = 0; i < N; i++) begin
        m_dma[i] = nd[i]; m_en[i] = ne[i]; m_ntf[i] = nn[i];
        m_flag[i] = nf[i]; m_owed[i] = no[i];
      end
    end
  end

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // model comparison on every cycle, away from the active edge
  always @(negedge clk) if (rst_n && !done_flag) begin
    chk("R3 dma_req model", dma_req, m_vec(0));
    chk("R5 xfer_req model", xfer_req, m_vec(1));
    chk("R8 cpu_irq model", cpu_irq, m_vec(2));
    chk("R13 rd_data model", rd_data, m_rd(rd_addr));
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    src_evt = '0; dma_ack = '0; xfer_done = '0; xfer_zero = '0; cfg_we = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick(); cfg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [N-1:0] exp);
    rd_addr = a; #1; chk(req, rd_data, exp);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 dma_req", dma_req, '0);
    chk("R1 xfer_req", xfer_req, '0);
    chk("R1 cpu_irq", cpu_irq, '0);
    for (int a = 0; a < 4; a++) rd(a[1:0], "R1 regs", '0);
    rst_n = 1;
    tick();

    // R2 R8 CPU path on source 0
    src_evt = 8'h01; tick(); idle();
    chk("R8 cpu_irq set", cpu_irq, 8'h01);
    rd(3, "R2 flag set", 8'h01);
    tick();
    chk("R8 cpu_irq held", cpu_irq, 8'h01);
    wr(3, 8'h01);
    rd(3, "R9 read after clear", 8'h00);
    chk("R9 cpu_irq cleared", cpu_irq, 8'h00);

    // R3 R4 DMA path on source 1, masked transfer-enable/notify
    wr(0, 8'h02); wr(1, 8'h02); wr(2, 8'h02);
    rd(0, "R13 readback dma", 8'h02);
    src_evt = 8'h06; tick(); idle();
    chk("R3 dma only", dma_req, 8'h02);
    chk("R3 xfer masked", xfer_req, 8'h00);
    chk("R3 cpu masked", cpu_irq, 8'h04);
    dma_ack = 8'h06; tick(); idle();
    chk("R4 dma cleared", dma_req, 8'h00);
    chk("R4 stray ack ignored", cpu_irq, 8'h04);
    rd(3, "R4 flags", 8'h04);
    wr(3, 8'h04); wr(2, 8'h00);

    // R5 R6 transfer path on source 3
    wr(1, 8'h0A);
    src_evt = 8'h08; tick(); idle();
    chk("R5 xfer only", xfer_req, 8'h08);
    chk("R5 no cpu", cpu_irq, 8'h00);
    xfer_done = 8'h08; tick(); idle();
    chk("R6 xfer cleared", xfer_req, 8'h00);
    chk("R6 no cpu", cpu_irq, 8'h00);
    rd(3, "R6 flag", 8'h00);

    // R7 zero count hand-off
    src_evt = 8'h08; tick(); idle();
    xfer_done = 8'h08; xfer_zero = 8'h08; tick(); idle();
    chk("R7 cpu raised", cpu_irq, 8'h08);
    chk("R7 xfer dropped", xfer_req, 8'h00);
    rd(1, "R7 enable cleared", 8'h02);
    wr(3, 8'h08);

    // R10 notify-CPU on source 4
    wr(1, 8'h12); wr(2, 8'h10);
    src_evt = 8'h10; tick(); idle();
    chk("R10 xfer req", xfer_req, 8'h10);
    xfer_done = 8'h10; tick(); idle();
    chk("R10 cpu raised", cpu_irq, 8'h10);
    chk("R10 xfer dropped", xfer_req, 8'h00);
    tick();
    chk("R10 cpu held", cpu_irq, 8'h10);
    rd(1, "R10 enable kept", 8'h12);
    wr(3, 8'h10);
    chk("R10 cleared", cpu_irq, 8'h00);

    // R11 event with simultaneous clear on source 5
    src_evt = 8'h20; tick(); idle();
    src_evt = 8'h20; cfg_we = 1; cfg_addr = 3; cfg_wdata = 8'h20; tick(); idle();
    chk("R11 event wins", cpu_irq, 8'h20);
    rd(3, "R11 flag", 8'h20);
    wr(3, 8'h20);

    // R12 hardware enable clear versus software write
    wr(1, 8'h1A);
    src_evt = 8'h08; tick(); idle();
    xfer_done = 8'h08; xfer_zero = 8'h08;
    cfg_we = 1; cfg_addr = 1; cfg_wdata = 8'hFF; tick(); idle();
    rd(1, "R12 hw clear wins", 8'hF7);
    chk("R12 cpu raised", cpu_irq, 8'h08);
    wr(3, 8'hFF); wr(1, 8'h00); wr(0, 8'h00);
    wr(2, 8'hA5);
    rd(2, "R13 readback notify", 8'hA5);

    // mixed random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      src_evt   = $urandom & $urandom;
      dma_ack   = $urandom & $urandom;
      xfer_done = $urandom & $urandom;
      xfer_zero = $urandom;
      cfg_we    = ($urandom % 6) == 0;
      cfg_addr  = $urandom;
      cfg_wdata = $urandom;
      rd_addr   = $urandom;
      tick();
    end
    idle();
    tick();
    summary();
  end
endmodule